// File: doc/BRIEF.md
# Variable-Position Sign/Zero Extender

This unit carries out one register micro-operation. It widens a 64-bit source value from a bit position that arrives at run time in a second operand. In sign mode the position is first wrapped to the operand size. The source bit at that wrapped position then becomes the fill value for every higher bit. The widened value is merged into the current destination according to the operand size, which is 1, 2, 4 or 8 bytes. In zero mode the position operand is used as given, every bit above it is cleared, and the whole 64-bit result is written.

In sign mode the unit can also update up to four condition-flag bits: carry, extended carry, zero and extended zero. A four-bit selection mask chooses which of them to touch. Each selected bit is set to the extracted sign bit, and every other flag bit passes through unchanged.

The logic is combinational. The result is held in one output register stage, and a valid bit travels alongside it.

Top module: `bitposExtender`

## Requirements
- R1: In sign mode the effective position is the position operand ANDed with (8 × size in bytes − 1). The size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. A position of 11 at size code 0 therefore acts as 3.
- R2: In sign mode, when the source bit at the effective position is 1, the result keeps source bits [pos:0] and sets every bit above pos.
- R3: In sign mode, when that source bit is 0, the result keeps source bits [pos:0] and clears every bit above pos.
- R4: In sign mode with size code 0 or 1, the output takes its low 8 or 16 bits from the result and all higher bits from the destination input.
- R5: In sign mode with size code 2, the output has the low 32 result bits and zeros in bits [63:32].
- R6: In sign mode with size code 3, all 64 result bits are written.
- R7: In zero mode (opSign = 0), the output is source bits [pos:0] with all higher bits cleared. The raw position operand is used and the size code is ignored. Any position of 63 or more returns the whole source.
- R8: In sign mode with flagEn = 1, each named flag selected by extMask is set to the sign bit. The mask bits are [0] carry, [1] extended carry, [2] zero and [3] extended zero. These flags sit at flag bits 0, 10, 6 and 11 respectively.
- R9: Flag bits other than the four named ones, and named bits whose mask bit is 0, pass through unchanged.
- R10: When flagEn = 0, or in zero mode, flagsOut equals flagsIn.
- R11: outValid follows inValid one clock later. Reset (rstN low) clears outValid, dstOut and flagsOut.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| opSign | input | 1 | 1 = sign extend, 0 = zero extend |
| sizeCode | input | 2 | Operand size: 0=1B, 1=2B, 2=4B, 3=8B |
| srcVal | input | 64 | Source operand |
| posVal | input | 8 | Bit-position operand |
| dstIn | input | 64 | Current destination value |
| flagsIn | input | 16 | Current flag word |
| flagEn | input | 1 | Enable flag update |
| extMask | input | 4 | Selects which named flags are written |
| outValid | output | 1 | Result valid |
| dstOut | output | 64 | Merged destination value |
| flagsOut | output | 16 | New flag word |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle valid latency;
- flag pass-through whenever flag update is off;
- the untouched non-named flag bits;
- destination bits preserved at byte size;
- the cleared upper word at 4-byte size;
- a full-mask, 8-byte sign operation writing each named flag with the same value as the top result bit.

Other behaviour can only be shown by the bench's directed scenarios, which compare exact expected values:
- the exact wrapped position;
- the fill pattern above that position;
- zero extension at positions beyond the word;
- partial flag masks with both sign values.

// File: rtl/bitposExtPkg.sv
package bitposExtPkg;

  // Named flag positions inside the flag word
  localparam int FLAG_CF  = 0;
  localparam int FLAG_ZF  = 6;
  localparam int FLAG_ECF = 10;
  localparam int FLAG_EZF = 11;

  typedef enum logic [2:0] {
    MERGE_BYTE  = 3'd0,
    MERGE_HALF  = 3'd1,
    MERGE_WORDZ = 3'd2,
    MERGE_FULL  = 3'd3,
    MERGE_NONE  = 3'd4
  } mergeKind_e;

  typedef struct packed {
    logic       signOp;
    logic       flagWrite;
    logic [5:0] posMask;
    mergeKind_e mergeKind;
  } extStrobes_t;

  // Expand the four-bit selection mask into flag-word positions
  function automatic logic [15:0] flagSelect(input logic [3:0] mask);
    logic [15:0] sel;
    sel = '0;
    sel[FLAG_CF]  = mask[0];
    sel[FLAG_ECF] = mask[1];
    sel[FLAG_ZF]  = mask[2];
    sel[FLAG_EZF] = mask[3];
    return sel;
  endfunction

endpackage

// File: rtl/bitposExtCtrl.sv
module bitposExtCtrl
  import bitposExtPkg::*;
#(
  parameter int LOG_W = 6
) (
  input  logic              opSign,
  input  logic [1:0]        sizeCode,
  input  logic              flagEn,
  output extStrobes_t       strobes
);

  always_comb begin
    strobes.signOp    = opSign;
    strobes.flagWrite = opSign & flagEn;
    // Position mask is (size in bits - 1)
    unique case (sizeCode)
      2'd0:    strobes.posMask = 6'd7;
      2'd1:    strobes.posMask = 6'd15;
      2'd2:    strobes.posMask = 6'd31;
      default: strobes.posMask = 6'd63;
    endcase
    if (!opSign) begin
      strobes.mergeKind = MERGE_NONE;
    end else begin
      unique case (sizeCode)
        2'd0:    strobes.mergeKind = MERGE_BYTE;
        2'd1:    strobes.mergeKind = MERGE_HALF;
        2'd2:    strobes.mergeKind = MERGE_WORDZ;
        default: strobes.mergeKind = MERGE_FULL;
      endcase
    end
  end

endmodule

// File: rtl/bitposExtDatapath.sv
module bitposExtDatapath
  import bitposExtPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int POS_W  = 8,
  parameter int FLAG_W = 16
) (
  input  extStrobes_t        strobes,
  input  logic [DATA_W-1:0]  srcVal,
  input  logic [POS_W-1:0]   posVal,
  input  logic [DATA_W-1:0]  dstIn,
  input  logic [FLAG_W-1:0]  flagsIn,
  input  logic [3:0]         extMask,
  output logic [DATA_W-1:0]  dstNext,
  output logic [FLAG_W-1:0]  flagsNext
);

  localparam int LOG_W = $clog2(DATA_W);
  localparam logic [LOG_W-1:0] TOP_POS = LOG_W'(DATA_W - 1);
  localparam logic [POS_W-1:0] TOP_RAW = POS_W'(DATA_W - 1);

  logic [LOG_W-1:0]  bitPos;
  logic              signBit;
  logic [DATA_W-1:0] keepMask;
  logic [DATA_W-1:0] signVal;
  logic [LOG_W-1:0]  zeroPos;
  logic [DATA_W-1:0] zeroMask;
  logic [DATA_W-1:0] zeroVal;
  logic [FLAG_W-1:0] flagSel;

  // Sign path: wrapped position and fill
  always_comb begin
    bitPos   = posVal[LOG_W-1:0] & strobes.posMask[LOG_W-1:0];
    signBit  = srcVal[bitPos];
    keepMask = {DATA_W{1'b1}} >> (TOP_POS - bitPos);
    signVal  = signBit ? (srcVal | ~keepMask) : (srcVal & keepMask);
  end

  // Zero path: raw position, saturated at the top bit
  always_comb begin
    zeroPos  = (posVal >= TOP_RAW) ? TOP_POS : posVal[LOG_W-1:0];
    zeroMask = {DATA_W{1'b1}} >> (TOP_POS - zeroPos);
    zeroVal  = srcVal & zeroMask;
  end

  // Size merge
  always_comb begin
    unique case (strobes.mergeKind)
      MERGE_BYTE:  dstNext = {dstIn[DATA_W-1:8], signVal[7:0]};
      MERGE_HALF:  dstNext = {dstIn[DATA_W-1:16], signVal[15:0]};
      MERGE_WORDZ: dstNext = {{(DATA_W-32){1'b0}}, signVal[31:0]};
      MERGE_FULL:  dstNext = signVal;
      default:     dstNext = zeroVal;
    endcase
  end

  // Flag update
  always_comb begin
    flagSel = FLAG_W'(flagSelect(extMask));
    if (!strobes.flagWrite)
      flagsNext = flagsIn;
    else if (signBit)
      flagsNext = flagsIn | flagSel;
    else
      flagsNext = flagsIn & ~flagSel;
  end

endmodule

// File: rtl/bitposExtender.sv
module bitposExtender
  import bitposExtPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int POS_W  = 8,
  parameter int FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              opSign,
  input  logic [1:0]        sizeCode,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [POS_W-1:0]  posVal,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic              flagEn,
  input  logic [3:0]        extMask,
  output logic              outValid,
  output logic [DATA_W-1:0] dstOut,
  output logic [FLAG_W-1:0] flagsOut
);

  localparam int LOG_W = $clog2(DATA_W);

  extStrobes_t       strobes;
  logic [DATA_W-1:0] dstNext;
  logic [FLAG_W-1:0] flagsNext;

  bitposExtCtrl #(.LOG_W(LOG_W)) ctrl (
    .opSign   (opSign),
    .sizeCode (sizeCode),
    .flagEn   (flagEn),
    .strobes  (strobes)
  );

  bitposExtDatapath #(.DATA_W(DATA_W), .POS_W(POS_W), .FLAG_W(FLAG_W)) dp (
    .strobes   (strobes),
    .srcVal    (srcVal),
    .posVal    (posVal),
    .dstIn     (dstIn),
    .flagsIn   (flagsIn),
    .extMask   (extMask),
    .dstNext   (dstNext),
    .flagsNext (flagsNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      dstOut   <= '0;
      flagsOut <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        dstOut   <= dstNext;
        flagsOut <= flagsNext;
      end
    end
  end

endmodule

// File: rtl/bitposExtenderChk.sv
module bitposExtenderChk
  import bitposExtPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int POS_W  = 8,
  parameter int FLAG_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              opSign,
  input logic [1:0]        sizeCode,
  input logic [DATA_W-1:0] dstIn,
  input logic [FLAG_W-1:0] flagsIn,
  input logic              flagEn,
  input logic [3:0]        extMask,
  input logic              outValid,
  input logic [DATA_W-1:0] dstOut,
  input logic [FLAG_W-1:0] flagsOut
);

  localparam logic [FLAG_W-1:0] NAMED = FLAG_W'(flagSelect(4'hF));

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid) else $error("valid latency"); // R11
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid) else $error("valid drop"); // R11
  AST_FLAG_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !(flagEn && opSign)) |=> flagsOut == $past(flagsIn)) else $error("flag pass"); // R10
  AST_OTHER_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (flagsOut & ~NAMED) == $past(flagsIn & ~NAMED)) else $error("other flags"); // R9
  AST_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSign && sizeCode == 2'd0) |=> dstOut[DATA_W-1:8] == $past(dstIn[DATA_W-1:8])) else $error("byte keep"); // R4
  AST_WORD_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSign && sizeCode == 2'd2) |=> dstOut[DATA_W-1:32] == '0) else $error("word upper"); // R5
  AST_FLAG_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSign && flagEn && sizeCode == 2'd3 && extMask == 4'hF) |=>
      (flagsOut[FLAG_CF] == dstOut[DATA_W-1] && flagsOut[FLAG_ZF] == dstOut[DATA_W-1] &&
       flagsOut[FLAG_ECF] == dstOut[DATA_W-1] && flagsOut[FLAG_EZF] == dstOut[DATA_W-1]))
    else $error("flag sign"); // R8

endmodule

bind bitposExtender bitposExtenderChk #(.DATA_W(DATA_W), .POS_W(POS_W), .FLAG_W(FLAG_W)) chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opSign(opSign), .sizeCode(sizeCode),
  .dstIn(dstIn), .flagsIn(flagsIn), .flagEn(flagEn), .extMask(extMask),
  .outValid(outValid), .dstOut(dstOut), .flagsOut(flagsOut)
);

// File: tb/bitposExtender_test.sv
`timescale 1ns/1ps
module bitposExtender_test;

  typedef struct {
    logic [63:0] dst;
    logic [15:0] flags;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        opSign = 1'b0;
  logic [1:0]  sizeCode = '0;
  logic [63:0] srcVal = '0;
  logic [7:0]  posVal = '0;
  logic [63:0] dstIn = '0;
  logic [15:0] flagsIn = '0;
  logic        flagEn = 1'b0;
  logic [3:0]  extMask = '0;
  logic        outValid;
  logic [63:0] dstOut;
  logic [15:0] flagsOut;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  bitposExtender uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSign(opSign), .sizeCode(sizeCode),
    .srcVal(srcVal), .posVal(posVal), .dstIn(dstIn), .flagsIn(flagsIn),
    .flagEn(flagEn), .extMask(extMask), .outValid(outValid), .dstOut(dstOut),
    .flagsOut(flagsOut)
  );

  function automatic expItem_t model(string tag, logic s, logic [1:0] sz, logic [63:0] src,
                                     logic [7:0] pos, logic [63:0] dst, logic [15:0] fl,
                                     logic fen, logic [3:0] msk);
    expItem_t it;
    int width;
    int wp;
    logic sb;
    logic [63:0] v;
    int flagIdx[4];
    flagIdx[0] = 0; flagIdx[1] = 10; flagIdx[2] = 6; flagIdx[3] = 11;
    it.tag = tag;
    it.flags = fl;
    if (s) begin
      width = 8 << sz;
      wp = int'(pos) % width;
      sb = src[wp];
      for (int b = 0; b < 64; b++) v[b] = (b <= wp) ? src[b] : sb;
      for (int b = 0; b < 64; b++) begin
        if (width == 32) it.dst[b] = (b < 32) ? v[b] : 1'b0;
        else if (width == 64) it.dst[b] = v[b];
        else it.dst[b] = (b < width) ? v[b] : dst[b];
      end
      if (fen) for (int i = 0; i < 4; i++) if (msk[i]) it.flags[flagIdx[i]] = sb;
    end else begin
      for (int b = 0; b < 64; b++) it.dst[b] = (b <= int'(pos)) ? src[b] : 1'b0;
    end
    return it;
  endfunction

  task automatic send(string tag, logic s, logic [1:0] sz, logic [63:0] src, logic [7:0] pos,
                      logic [63:0] dst, logic [15:0] fl, logic fen, logic [3:0] msk);
    @(negedge clk);
    inValid = 1'b1; opSign = s; sizeCode = sz; srcVal = src; posVal = pos;
    dstIn = dst; flagsIn = fl; flagEn = fen; extMask = msk;
    expQ.push_back(model(tag, s, sz, src, pos, dst, fl, fen, msk));
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor: compare results as they appear
  always @(negedge clk) begin
    if (rstN && outValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected outValid, actual 1 expected 0");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (dstOut !== e.dst || flagsOut !== e.flags) begin
          errors++;
          $display("FAIL %s: actual dst=%h flags=%h expected dst=%h flags=%h",
                   e.tag, dstOut, flagsOut, e.dst, e.flags);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || dstOut !== '0 || flagsOut !== '0) begin
      errors++;
      $display("FAIL R11 reset: actual v=%b d=%h f=%h expected all zero", outValid, dstOut, flagsOut);
    end
    rstN = 1'b1;

    // R2 R4: byte, sign bit 1 at position 3
    send("R2", 1, 2'd0, 64'h0000_0000_0000_0008, 8'd3, 64'hAAAA_AAAA_AAAA_AAAA, 16'h0, 0, 4'h0);
    // R1: position 11 wraps to 3 at byte size
    send("R1", 1, 2'd0, 64'h0000_0000_0000_00F5, 8'd11, 64'h1234_5678_9ABC_DEF0, 16'h0, 0, 4'h0);
    // R3 R4: half, sign bit 0
    send("R3", 1, 2'd1, 64'hFFFF_FFFF_FFFF_7ABC, 8'd15, 64'h5555_5555_5555_5555, 16'h0, 0, 4'h0);
    // R5: word, position 40 wraps to 8
    send("R5", 1, 2'd2, 64'hDEAD_BEEF_0000_0155, 8'd40, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 0, 4'h0);
    // R6: full size, position 63
    send("R6", 1, 2'd3, 64'h8000_0000_0000_0001, 8'd63, 64'h0, 16'h0, 0, 4'h0);
    // R1 R6: position 70 wraps to 6
    send("R1", 1, 2'd3, 64'h0F0F_0F0F_0F0F_0F4F, 8'd70, 64'h0, 16'h0, 0, 4'h0);
    // R7: zero extension
    send("R7", 0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd5, 64'h1111_1111_1111_1111, 16'h0, 0, 4'h0);
    send("R7", 0, 2'd1, 64'h8123_4567_89AB_CDEF, 8'd63, 64'h0, 16'h0, 0, 4'h0);
    send("R7", 0, 2'd2, 64'h8123_4567_89AB_CDEF, 8'd200, 64'h0, 16'h0, 0, 4'h0);
    // R8 R9: sign 1, partial mask
    send("R8", 1, 2'd0, 64'h80, 8'd7, 64'h0, 16'h0F0F, 1, 4'b0101);
    // R8 R9: sign 0, full mask
    send("R8", 1, 2'd1, 64'h0, 8'd9, 64'h0, 16'hFFFF, 1, 4'b1111);
    // R9: sign 1, only extended zero selected
    send("R9", 1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'd0, 64'h0, 16'h0000, 1, 4'b1000);
    // R10: flag update disabled
    send("R10", 1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'd2, 64'h0, 16'hA5A5, 0, 4'hF);
    // R10: zero mode ignores flag enable
    send("R10", 0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'd2, 64'h0, 16'h5A5A, 1, 4'hF);
    idle();
    @(negedge clk);
    // R11: valid drops one cycle after the input does
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R11: actual outValid=%b expected 0", outValid);
    end
    repeat (2) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R11: actual %0d pending results expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule